// File: doc/BRIEF.md
# Deferred-Compare Condition Evaluator

This block decides, every cycle, whether the instruction being issued should execute. It does not store NZCV flags. When a flag-setting data-processing operation retires, the block saves a pair of 32-bit operands and a tag that names how the pair is combined: subtract, XOR or AND. When a later instruction word is presented, its 4-bit condition field is resolved directly against that saved pair. The block returns an execute bit, and raises a trap for condition codes that the current tag cannot answer.

The record side takes the retiring operation's opcode, its S bit, its two operands, its result and the shifter carry-out. It also keeps a single carry bit. That bit is loaded from the shifter for logical operations and from the 33-bit sum for ADD. The three carry-consuming arithmetic opcodes cannot be recorded; they raise a record trap instead.

Top module: `deferred_cond_eval`

## Requirements
- R1: The condition code is bits 31:28 of `eval_insn`, and the other bits have no effect. Code 4'hE gives execute=1. Code 4'hF gives execute=0. Neither code traps, whatever the tag.
- R2: In subtract mode with saved pair (a,b), the codes mean the following: 0 is a==b, 1 is a!=b, 2 is unsigned a>=b, 3 is unsigned a<b, 8 is unsigned a>b and 9 is unsigned a<=b.
- R3: In subtract mode, the codes compare a and b as signed 32-bit values: A is a>=b, B is a<b, C is a>b and D is a<=b.
- R4: In subtract mode, code 4 executes when bit 31 of the 32-bit difference a-b is 1, and code 5 executes when it is 0.
- R5: Codes 6 and 7 give trap=1 and execute=0 in every mode.
- R6: In XOR or AND mode, r = a^b or a&b. Code 0 executes when r==0, code 1 when r!=0, code 4 when r[31]=1 and code 5 when r[31]=0. Every code other than 0, 1, 4, 5, E and F traps with execute=0.
- R7: A record with S=1 saves the pair as follows, with opcode values 2 SUB, 3 RSB, 4 ADD, 8 TST, 9 TEQ, A CMP and B CMN. SUB and CMP save (op1,op2) in subtract mode. RSB saves (op2,op1). ADD saves (op2,-op1). CMN saves (op1,-op2). TST saves (op1,op2) in AND mode. TEQ saves (op1,op2) in XOR mode.
- R8: A record with S=1 of a logical opcode saves (result,0) in subtract mode and copies the shifter carry into `carry_flag`. The logical opcodes are 0 AND, 1 EOR, C ORR, D MOV, E BIC and F MVN.
- R9: ADD with S=1 sets `carry_flag` to bit 32 of the unsigned sum op1+op2. The compare opcodes leave `carry_flag` unchanged.
- R10: A valid record of opcode 5, 6 or 7 raises `rec_trap` in the same cycle and changes neither the saved state nor the carry.
- R11: A record with S=0, or with `rec_valid` low, changes no state.
- R12: After reset the tag is subtract mode, both operands are zero and `carry_flag` is 0.
- R13: An evaluate in the same cycle as a record sees the state from before that record. The new state is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | A data-processing operation retires this cycle |
| rec_op | input | 4 | Opcode of the retiring operation |
| rec_s | input | 1 | Flag-setting bit of the retiring operation |
| rec_op1 | input | 32 | First operand |
| rec_op2 | input | 32 | Second (shifted) operand |
| rec_result | input | 32 | Result of a logical operation |
| rec_shc | input | 1 | Shifter carry-out |
| rec_trap | output | 1 | Undefined trap for opcodes 5 to 7 |
| eval_insn | input | 32 | Instruction word being issued |
| eval_exec | output | 1 | The instruction executes |
| eval_trap | output | 1 | Undefined-condition trap |
| carry_flag | output | 1 | Saved carry bit |

## Verification
A wrong tag or a swapped or unnegated operand pair does not show up when it is recorded. It shows up only at the next evaluate of a code that the fault changes. For that reason, each recording case is followed by evaluates that only pass if the tag is right and the pair is right, including its order and sign. An operand captured with the wrong sign makes the signed and unsigned codes disagree, so the tests pair those codes against each other. Carry faults appear on `carry_flag` one cycle after the record.

// File: rtl/deferred_cond_eval.sv
module deferred_cond_eval #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rec_valid,
  input  logic [3:0]   rec_op,
  input  logic         rec_s,
  input  logic [W-1:0] rec_op1,
  input  logic [W-1:0] rec_op2,
  input  logic [W-1:0] rec_result,
  input  logic         rec_shc,
  output logic         rec_trap,
  input  logic [31:0]  eval_insn,
  output logic         eval_exec,
  output logic         eval_trap,
  output logic         carry_flag
);
  localparam logic [1:0] KIND_SUB = 2'd0;
  localparam logic [1:0] KIND_XOR = 2'd1;
  localparam logic [1:0] KIND_AND = 2'd2;

  logic [W-1:0] cmp_a, cmp_b, nxt_a, nxt_b;
  logic [1:0]   kind, nxt_kind;
  logic         nxt_c, upd;
  logic [W:0]   sum33;

  assign rec_trap = rec_valid && (rec_op inside {4'h5, 4'h6, 4'h7});
  assign upd      = rec_valid && rec_s && !rec_trap;
  assign sum33    = {1'b0, rec_op1} + {1'b0, rec_op2};

  always_comb begin
    nxt_a    = cmp_a;
    nxt_b    = cmp_b;
    nxt_kind = kind;
    nxt_c    = carry_flag;
    if (upd) begin
      case (rec_op)
        4'h2, 4'hA: begin nxt_a = rec_op1; nxt_b = rec_op2;  nxt_kind = KIND_SUB; end
        4'h3:       begin nxt_a = rec_op2; nxt_b = rec_op1;  nxt_kind = KIND_SUB; end
        4'h4: begin
          nxt_a = rec_op2; nxt_b = -rec_op1; nxt_kind = KIND_SUB;
          nxt_c = sum33[W];
        end
        4'hB:       begin nxt_a = rec_op1; nxt_b = -rec_op2; nxt_kind = KIND_SUB; end
        4'h8:       begin nxt_a = rec_op1; nxt_b = rec_op2;  nxt_kind = KIND_AND; end
        4'h9:       begin nxt_a = rec_op1; nxt_b = rec_op2;  nxt_kind = KIND_XOR; end
        4'h0, 4'h1, 4'hC, 4'hD, 4'hE, 4'hF: begin
          nxt_a = rec_result; nxt_b = '0; nxt_kind = KIND_SUB;
          nxt_c = rec_shc;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a      <= '0;
      cmp_b      <= '0;
      kind       <= KIND_SUB;
      carry_flag <= 1'b0;
    end else begin
      cmp_a      <= nxt_a;
      cmp_b      <= nxt_b;
      kind       <= nxt_kind;
      carry_flag <= nxt_c;
    end
  end

  logic [3:0]   code;
  logic [W-1:0] diff, bits;
  logic         eq, ult, slt;

  assign code = eval_insn[31:28];
  assign diff = cmp_a - cmp_b;
  assign bits = (kind == KIND_XOR) ? (cmp_a ^ cmp_b) : (cmp_a & cmp_b);
  assign eq   = (cmp_a == cmp_b);
  assign ult  = (cmp_a < cmp_b);
  assign slt  = ($signed(cmp_a) < $signed(cmp_b));

  always_comb begin
    eval_exec = 1'b0;
    eval_trap = 1'b0;
    if (kind == KIND_SUB) begin
      case (code)
        4'h0: eval_exec = eq;
        4'h1: eval_exec = !eq;
        4'h2: eval_exec = !ult;
        4'h3: eval_exec = ult;
        4'h4: eval_exec = diff[W-1];
        4'h5: eval_exec = !diff[W-1];
        4'h8: eval_exec = !ult && !eq;
        4'h9: eval_exec = ult || eq;
        4'hA: eval_exec = !slt;
        4'hB: eval_exec = slt;
        4'hC: eval_exec = !slt && !eq;
        4'hD: eval_exec = slt || eq;
        4'hE: eval_exec = 1'b1;
        4'hF: eval_exec = 1'b0;
        default: eval_trap = 1'b1;
      endcase
    end else begin
      case (code)
        4'h0: eval_exec = (bits == '0);
        4'h1: eval_exec = (bits != '0);
        4'h4: eval_exec = bits[W-1];
        4'h5: eval_exec = !bits[W-1];
        4'hE: eval_exec = 1'b1;
        4'hF: eval_exec = 1'b0;
        default: eval_trap = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rec_valid,
  input logic [3:0]  rec_op,
  input logic        rec_s,
  input logic        rec_trap,
  input logic [31:0] eval_insn,
  input logic        eval_exec,
  input logic        eval_trap,
  input logic        carry_flag
);
  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_insn[31:28] == 4'hE |-> eval_exec && !eval_trap); // R1
  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_insn[31:28] == 4'hF |-> !eval_exec && !eval_trap); // R1
  AST_OVF_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    eval_insn[31:28] inside {4'h6, 4'h7} |-> eval_trap && !eval_exec); // R5
  AST_TRAP_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    eval_trap |-> !eval_exec); // R6
  AST_CARRY_OP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_op inside {4'h5, 4'h6, 4'h7} |-> rec_trap); // R10
  AST_TRAP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    rec_trap |=> $stable(carry_flag)); // R10
  AST_IDLE_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid && rec_s) |=> $stable(carry_flag)); // R11
endmodule

bind deferred_cond_eval cond_eval_chk u_chk (.*);

// File: tb/tb_deferred_cond_eval.sv
module tb_deferred_cond_eval;
  logic        clk = 0, rst_n = 0;
  logic        rec_valid = 0, rec_s = 0, rec_shc = 0;
  logic [3:0]  rec_op = 0;
  logic [31:0] rec_op1 = 0, rec_op2 = 0, rec_result = 0, eval_insn = 0;
  logic        rec_trap, eval_exec, eval_trap, carry_flag;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  deferred_cond_eval dut (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] o1, o2, res;
    logic [3:0]  code;
    logic        ex, tr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'hA, 32'd5, 32'd5, 32'd0, 4'h0, 1'b1, 1'b0},          // R2 eq
    '{4'hA, 32'd5, 32'd5, 32'd0, 4'h1, 1'b0, 1'b0},          // R2 ne
    '{4'hA, 32'd1, 32'hFFFFFFFF, 32'd0, 4'h2, 1'b0, 1'b0},   // R2 hs
    '{4'hA, 32'd1, 32'hFFFFFFFF, 32'd0, 4'h3, 1'b1, 1'b0},   // R2 lo
    '{4'hA, 32'd1, 32'hFFFFFFFF, 32'd0, 4'hB, 1'b0, 1'b0},   // R3 lt
    '{4'hA, 32'd1, 32'hFFFFFFFF, 32'd0, 4'hC, 1'b1, 1'b0},   // R3 gt
    '{4'hA, 32'd3, 32'd7, 32'd0, 4'h4, 1'b1, 1'b0},          // R4 mi
    '{4'hA, 32'd3, 32'd7, 32'd0, 4'h5, 1'b0, 1'b0},          // R4 pl
    '{4'hA, 32'd3, 32'd7, 32'd0, 4'h8, 1'b0, 1'b0},          // R2 hi
    '{4'hA, 32'd3, 32'd7, 32'd0, 4'h9, 1'b1, 1'b0},          // R2 ls
    '{4'h2, 32'd7, 32'd3, 32'd0, 4'hA, 1'b1, 1'b0},          // R3 ge
    '{4'h2, 32'd7, 32'd3, 32'd0, 4'hD, 1'b0, 1'b0},          // R3 le
    '{4'h3, 32'd7, 32'd3, 32'd0, 4'h3, 1'b1, 1'b0},          // R7 rsb swap
    '{4'h4, 32'd5, 32'd3, 32'd0, 4'h0, 1'b0, 1'b0},          // R7 add (3,-5)
    '{4'h4, 32'd5, 32'd3, 32'd0, 4'hC, 1'b1, 1'b0},          // R7 add signed
    '{4'h4, 32'd5, 32'hFFFFFFFB, 32'd0, 4'h0, 1'b1, 1'b0},   // R7 add zero sum
    '{4'hB, 32'd4, 32'hFFFFFFFC, 32'd0, 4'h0, 1'b1, 1'b0},   // R7 cmn
    '{4'h8, 32'hF0, 32'h0F, 32'd0, 4'h0, 1'b1, 1'b0},        // R6 tst zero
    '{4'h8, 32'hF0, 32'h0F, 32'd0, 4'h2, 1'b0, 1'b1},        // R6 tst trap
    '{4'h9, 32'h80000000, 32'd0, 32'd0, 4'h4, 1'b1, 1'b0},   // R6 teq mi
    '{4'h9, 32'h80000000, 32'd0, 32'd0, 4'h8, 1'b0, 1'b1},   // R6 teq trap
    '{4'hD, 32'd9, 32'd9, 32'd0, 4'h0, 1'b1, 1'b0},          // R8 mov zero
    '{4'hF, 32'd1, 32'd1, 32'h80000000, 4'hB, 1'b1, 1'b0},   // R8 mvn negative
    '{4'hA, 32'd5, 32'd5, 32'd0, 4'h6, 1'b0, 1'b1}           // R5 overflow code
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rec(input logic [3:0] op, input logic s, input logic [31:0] a, b, r,
                     input logic shc);
    @(negedge clk);
    rec_valid = 1; rec_op = op; rec_s = s; rec_op1 = a; rec_op2 = b;
    rec_result = r; rec_shc = shc;
    @(negedge clk);
    rec_valid = 0; rec_s = 0;
  endtask

  task automatic ev(input logic [3:0] code, input string req,
                    input logic ex, input logic tr);
    eval_insn = {code, 28'h5A3C961};
    #1;
    chk(req, {30'd0, eval_exec, eval_trap}, {30'd0, ex, tr});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    ev(4'h0, "R12 eq", 1, 0);
    ev(4'h1, "R12 ne", 0, 0);
    ev(4'h4, "R12 mi", 0, 0);
    ev(4'hA, "R12 ge", 1, 0);
    chk("R12 carry", {31'd0, carry_flag}, 0);

    for (int i = 0; i < NV; i++) begin
      rec(VEC[i].op, 1, VEC[i].o1, VEC[i].o2, VEC[i].res, 0);
      ev(VEC[i].code, $sformatf("R2-table entry %0d", i), VEC[i].ex, VEC[i].tr);
    end

    // R1 always/never in AND mode, low bits ignored
    rec(4'h8, 1, 32'hF0, 32'h0F, 0, 0);
    ev(4'hE, "R1 always", 1, 0);
    ev(4'hF, "R1 never", 0, 0);
    eval_insn = 32'h0FFFFFFF; #1;
    chk("R1 low bits", {31'd0, eval_exec}, 1);

    // R9 carry from sum
    rec(4'h4, 1, 32'hFFFFFFFF, 32'd1, 0, 0);
    chk("R9 add carry", {31'd0, carry_flag}, 1);
    rec(4'h4, 1, 32'd1, 32'd1, 0, 1);
    chk("R9 add no carry", {31'd0, carry_flag}, 0);
    // R8 shifter carry
    rec(4'hD, 1, 0, 0, 32'd4, 1);
    chk("R8 mov carry", {31'd0, carry_flag}, 1);
    rec(4'hA, 1, 32'd5, 32'd5, 0, 0);
    chk("R9 cmp keeps carry", {31'd0, carry_flag}, 1);

    // R11 no S bit
    rec(4'hA, 0, 32'd1, 32'd2, 0, 0);
    ev(4'h0, "R11 no S", 1, 0);
    rec(4'hD, 0, 0, 0, 32'd7, 0);
    chk("R11 carry", {31'd0, carry_flag}, 1);

    // R10 carry-consuming ops trap
    @(negedge clk);
    rec_valid = 1; rec_op = 4'h6; rec_s = 1; rec_op1 = 1; rec_op2 = 2;
    rec_result = 9; rec_shc = 0;
    #1;
    chk("R10 rec_trap", {31'd0, rec_trap}, 1);
    @(negedge clk);
    rec_valid = 0; rec_s = 0;
    ev(4'h0, "R10 state kept", 1, 0);
    chk("R10 carry kept", {31'd0, carry_flag}, 1);

    // R13 same-cycle record and evaluate
    @(negedge clk);
    rec_valid = 1; rec_op = 4'hA; rec_s = 1; rec_op1 = 1; rec_op2 = 2;
    ev(4'h0, "R13 old value", 1, 0);
    @(negedge clk);
    rec_valid = 0; rec_s = 0;
    ev(4'h0, "R13 new value", 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule